// File: doc/BRIEF.md
# Dual-Limit Window Watchdog Comparator

This block watches a stream of signed low-resolution conversion results. Each result arrives with a valid strobe. The block first removes a programmable offset from it, limiting the answer to the signed sample range. It then compares the corrected value with two programmable limits. Each limit has its own direction bit, which decides whether a value strictly above the limit or strictly below it counts as a trip.

Every trip sets a per-limit status bit and a shared interrupt flag. Both stay set until the host clears them. Setting the upper limit to trip on "above" and the lower limit to trip on "below" gives an alarm for values outside the window. Setting the lower limit to trip on "above" and the upper limit to trip on "below" makes both status bits set together when the value lies inside the window.

Top module: `wdog_window_top`

## Requirements
- R1: While reset is asserted and after it is released, `irq`, `trip_a` and `trip_b` are 0 until a trip occurs.
- R2: The corrected value is `smp_data - ofs_coef` as signed two's-complement numbers. It saturates to the largest or smallest value of the signed `W`-bit range and never wraps. For W=9 that range is -256 to +255.
- R3: For a limit whose direction bit is 1, a corrected value strictly greater than the limit trips it. For direction bit 0, a corrected value strictly less than the limit trips it. A value equal to the limit never trips.
- R4: A status bit and `irq` stay at 1 on every cycle after a trip until `irq_clr` is sampled high.
- R5: If `irq_clr` is high on the same edge where a new trip is registered, the tripped bit and `irq` stay 1.
- R6: `irq_clr` with no new trip on that edge clears all status bits and `irq` after that edge.
- R7: `irq` equals the OR of `trip_a` and `trip_b` on every cycle.
- R8: On a cycle where `smp_valid` is 0, `smp_data` and `ofs_coef` have no effect on any output.
- R9: The edge that accepts a sample also samples `ofs_coef`. The next edge compares the corrected value against `lim_a`, `lim_b`, `dir_a` and `dir_b`, and registers the status bits. A trip is therefore visible only after the second edge.
- R10: The two limits are checked independently. One sample may set either status bit, or both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | W | Signed raw sample |
| ofs_coef | input | W | Signed offset to subtract |
| lim_a | input | W | Signed limit A |
| lim_b | input | W | Signed limit B |
| dir_a | input | 1 | Limit A sense: 1 above, 0 below |
| dir_b | input | 1 | Limit B sense: 1 above, 0 below |
| irq_clr | input | 1 | Clear status bits and interrupt |
| irq | output | 1 | Sticky interrupt flag |
| trip_a | output | 1 | Sticky status for limit A |
| trip_b | output | 1 | Sticky status for limit B |

## Verification
The bench drives samples equal to each limit. A design that used a non-strict compare would trip on those samples. It drives extreme samples against offsets of both signs. If the subtraction wrapped, a large negative result would turn positive, trip an "above" limit and miss a "below" one. It pulses the clear on the same edge as a fresh trip, where a clear-priority design would drop the alarm. It also drives extreme data with the strobe low, and checks the cycle right after a sample, where a design with a shorter pipeline would raise the flag one cycle early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int NUM_LIM = 2;

    typedef enum logic {
        SENSE_BELOW = 1'b0,
        SENSE_ABOVE = 1'b1
    } sense_e;

endpackage

// File: rtl/wdog_ofs_sat.sv
module wdog_ofs_sat #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_smp,
    input  logic [W-1:0] ofs,
    output logic         out_valid,
    output logic [W-1:0] out_val
);

    localparam int XW = W + 1;
    localparam logic signed [XW-1:0] MAX_V = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] MIN_V = {2'b11, {(W-1){1'b0}}};

    typedef struct packed {
        logic         vld;
        logic [W-1:0] val;
    } stage_t;

    stage_t st_d, st_q;
    logic signed [XW-1:0] diff;

    always_comb begin
        st_d = st_q;
        diff = $signed({in_smp[W-1], in_smp}) - $signed({ofs[W-1], ofs});
        st_d.vld = in_valid;
        if (in_valid) begin
            if (diff > MAX_V) begin
                st_d.val = MAX_V[W-1:0];
            end else if (diff < MIN_V) begin
                st_d.val = MIN_V[W-1:0];
            end else begin
                st_d.val = diff[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_val   = st_q.val;

    // R2
    sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_smp[W-1] && (ofs[W-1] || ofs == '0)) |=> !out_val[W-1]);

    // R2
    sat_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_smp[W-1] && !ofs[W-1]) |=> out_val[W-1]);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_val) && !out_valid));

endmodule

// File: rtl/wdog_lim_cmp.sv
module wdog_lim_cmp
    import wdog_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         val_vld,
    input  logic [W-1:0] val,
    input  logic [W-1:0] lim,
    input  logic         dir,
    output logic         hit
);

    sense_e sense;
    logic   above;
    logic   below;

    always_comb begin
        sense = sense_e'(dir);
        above = $signed(val) > $signed(lim);
        below = $signed(val) < $signed(lim);
        hit   = 1'b0;
        if (val_vld) begin
            case (sense)
                SENSE_ABOVE: hit = above;
                SENSE_BELOW: hit = below;
                default:     hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_sticky.sv
module wdog_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic         clr,
    output logic [N-1:0] trip,
    output logic         irq
);

    typedef struct packed {
        logic         irq;
        logic [N-1:0] trip;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d      = fl_q;
        fl_d.trip = (fl_q.trip & ~{N{clr}}) | hit;
        fl_d.irq  = (fl_q.irq & ~clr) | (|hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign trip = fl_q.trip;
    assign irq  = fl_q.irq;

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    // R5
    clr_vs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> irq);

    // R6
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(|hit)) |=> (trip == '0 && !irq));

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
    import wdog_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic [W-1:0] ofs_coef,
    input  logic [W-1:0] lim_a,
    input  logic [W-1:0] lim_b,
    input  logic         dir_a,
    input  logic         dir_b,
    input  logic         irq_clr,
    output logic         irq,
    output logic         trip_a,
    output logic         trip_b
);

    logic                   corr_vld;
    logic [W-1:0]           corr_val;
    logic [NUM_LIM-1:0][W-1:0] lim_arr;
    logic [NUM_LIM-1:0]     dir_arr;
    logic [NUM_LIM-1:0]     hit_vec;
    logic [NUM_LIM-1:0]     trip_vec;

    assign lim_arr = {lim_b, lim_a};
    assign dir_arr = {dir_b, dir_a};

    wdog_ofs_sat #(.W(W)) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_smp    (smp_data),
        .ofs       (ofs_coef),
        .out_valid (corr_vld),
        .out_val   (corr_val)
    );

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
        wdog_lim_cmp #(.W(W)) u_cmp (
            .val_vld (corr_vld),
            .val     (corr_val),
            .lim     (lim_arr[g]),
            .dir     (dir_arr[g]),
            .hit     (hit_vec[g])
        );
    end

    wdog_sticky #(.N(NUM_LIM)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_vec),
        .clr   (irq_clr),
        .trip  (trip_vec),
        .irq   (irq)
    );

    assign trip_a = trip_vec[0];
    assign trip_b = trip_vec[1];

    // R7
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (trip_a | trip_b));

    // R3
    eq_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_vld && corr_val == lim_a && !trip_a) |=> !trip_a);

endmodule

// File: tb/tb_wdog_window_top.sv
module tb_wdog_window_top;

    localparam int W    = 9;
    localparam int VMAX = (1 << (W - 1)) - 1;
    localparam int VMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n;
    logic         smp_valid;
    logic [W-1:0] smp_data;
    logic [W-1:0] ofs_coef;
    logic [W-1:0] lim_a;
    logic [W-1:0] lim_b;
    logic         dir_a;
    logic         dir_b;
    logic         irq_clr;
    logic         irq;
    logic         trip_a;
    logic         trip_b;

    int ofs_i, la_i, lb_i;
    int n_chk = 0;
    int n_bad = 0;

    // reference state
    bit       m_vld;
    int       m_val;
    bit [1:0] m_trip;

    always #5 clk = ~clk;

    assign ofs_coef = ofs_i[W-1:0];
    assign lim_a    = la_i[W-1:0];
    assign lim_b    = lb_i[W-1:0];

    wdog_window_top #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .ofs_coef  (ofs_coef),
        .lim_a     (lim_a),
        .lim_b     (lim_b),
        .dir_a     (dir_a),
        .dir_b     (dir_b),
        .irq_clr   (irq_clr),
        .irq       (irq),
        .trip_a    (trip_a),
        .trip_b    (trip_b)
    );

    function automatic int sat_sub(int s, int o);
        int d;
        d = s - o;
        if (d > VMAX) return VMAX;
        if (d < VMIN) return VMIN;
        return d;
    endfunction

    function automatic bit crosses(int v, int l, bit up);
        return up ? (v > l) : (v < l);
    endfunction

    task automatic check(string req);
        bit [1:0] got;
        got = {trip_b, trip_a};
        n_chk++;
        if (got !== m_trip) begin
            n_bad++;
            $display("FAIL %s trip actual=%b expected=%b", req, got, m_trip);
        end
        n_chk++;
        if (irq !== (|m_trip)) begin
            n_bad++;
            $display("FAIL %s/R7 irq actual=%b expected=%b", req, irq, |m_trip);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(bit v, int s, bit c, string req);
        bit [1:0] h;
        smp_valid = v;
        smp_data  = s[W-1:0];
        irq_clr   = c;
        @(posedge clk);
        h[0] = m_vld && crosses(m_val, la_i, dir_a);
        h[1] = m_vld && crosses(m_val, lb_i, dir_b);
        m_trip = (m_trip & ~{c, c}) | h;
        m_vld  = v;
        if (v) m_val = sat_sub(s, ofs_i);
        @(negedge clk);
        check(req);
    endtask

    function automatic int rnd_val();
        return int'($urandom_range(VMAX - VMIN)) + VMIN;
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; irq_clr = 1'b0;
        ofs_i = 0; la_i = 10; lb_i = -10; dir_a = 1'b1; dir_b = 1'b0;
        m_vld = 0; m_val = 0; m_trip = 2'b00;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R3: equal to limit never trips; R9: not visible after one edge
        step(1, 10, 0, "R3");
        step(0, 0, 0, "R3");
        step(1, -10, 0, "R3");
        step(0, 0, 0, "R3");
        step(1, 11, 0, "R9");
        n_chk++;
        if (trip_a !== 1'b0) begin
            n_bad++; $display("FAIL R9 early trip actual=%b expected=0", trip_a);
        end
        step(0, 0, 0, "R3");
        // R4: hold without clear
        step(0, 0, 0, "R4");
        step(0, 0, 0, "R4");
        // R6: clear alone
        step(0, 0, 1, "R6");
        n_chk++;
        if ({irq, trip_b, trip_a} !== 3'b000) begin
            n_bad++; $display("FAIL R6 flags actual=%b expected=000", {irq, trip_b, trip_a});
        end
        // R5: clear on the edge of a new trip
        step(1, -11, 0, "R5");
        step(0, 0, 1, "R5");
        n_chk++;
        if (trip_b !== 1'b1) begin
            n_bad++; $display("FAIL R5 trip_b actual=%b expected=1", trip_b);
        end
        step(0, 0, 1, "R6");

        // R2: saturation at both ends
        ofs_i = 5; la_i = 0; dir_a = 1'b1; lb_i = VMIN; dir_b = 1'b0;
        step(1, VMIN, 0, "R2");
        step(0, 0, 0, "R2");
        n_chk++;
        if ({trip_b, trip_a} !== 2'b00) begin
            n_bad++; $display("FAIL R2 low sat actual=%b expected=00", {trip_b, trip_a});
        end
        ofs_i = -10; la_i = VMAX - 1; dir_a = 1'b1; lb_i = 0; dir_b = 1'b0;
        step(1, VMAX, 0, "R2");
        step(0, 0, 0, "R2");
        n_chk++;
        if ({trip_b, trip_a} !== 2'b01) begin
            n_bad++; $display("FAIL R2 high sat actual=%b expected=01", {trip_b, trip_a});
        end
        step(0, 0, 1, "R6");

        // R8: strobe low with extreme data and offset
        ofs_i = VMIN; la_i = 0; lb_i = 0; dir_a = 1'b1; dir_b = 1'b0;
        step(0, VMAX, 0, "R8");
        step(0, VMIN, 0, "R8");
        step(0, VMAX, 0, "R8");

        // R10: inside window sets both bits
        ofs_i = 0; la_i = -20; dir_a = 1'b1; lb_i = 20; dir_b = 1'b0;
        step(1, 0, 0, "R10");
        step(0, 0, 0, "R10");
        n_chk++;
        if ({trip_b, trip_a} !== 2'b11) begin
            n_bad++; $display("FAIL R10 inside actual=%b expected=11", {trip_b, trip_a});
        end
        step(0, 0, 1, "R6");
        // outside window alarm
        la_i = 20; dir_a = 1'b1; lb_i = -20; dir_b = 1'b0;
        step(1, 5, 0, "R10");
        step(1, -30, 0, "R10");
        step(0, 0, 0, "R10");
        step(0, 0, 1, "R6");

        // constrained random mix
        for (int i = 0; i < 2000; i++) begin
            bit v, c;
            int s;
            if ($urandom_range(15) == 0) begin
                la_i  = rnd_val();
                lb_i  = rnd_val();
                dir_a = 1'($urandom_range(1));
                dir_b = 1'($urandom_range(1));
            end
            if ($urandom_range(7) == 0) ofs_i = rnd_val();
            v = ($urandom_range(3) != 0);
            c = ($urandom_range(9) == 0);
            case ($urandom_range(5))
                0:       s = la_i + ofs_i;
                1:       s = lb_i + ofs_i;
                2:       s = (($urandom_range(1) == 1) ? VMAX : VMIN);
                default: s = rnd_val();
            endcase
            if (s > VMAX) s = VMAX;
            if (s < VMIN) s = VMIN;
            step(v, s, c, "R3/R4");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule